// File: doc/BRIEF.md
# A/D Converter Conversion Controller

This block is the digital front end of a successive-approximation analog-to-digital converter. A small register slave holds one control word and one read-only result word. The control word selects how a conversion begins: a software start, an edge on one of six trigger inputs, or a free-running burst that walks through a channel mask. The block sends a one-cycle start pulse and a channel number to an abstract converter core. It also sends a divided conversion clock enable, which stays off and held at phase zero while no conversion runs.

When the core reports completion, the block latches the 10-bit result and the channel number into the result word and sets a completion flag. That flag drives the interrupt request. The flag and an overrun flag are cleared as a side effect of reading the result word. Writing the control word also acts on the flag: it clears it when idle, and sets it and restarts the conversion when busy.

Top module: `adc_seq_ctl`

## Requirements
- R1: Writing the control word (address 0) with bit 16 = 0 and bits 26:24 = 001 raises `conv_start` for one cycle in the next cycle. `conv_chan` is then the lowest set bit of mask bits 7:0, or 0 when the mask is zero.
- R2: With bit 16 = 0 and bits 26:24 = code 2..7, trigger input `trig_in[code-2]` is used. After a two-flop synchronizer it is XORed with bit 27, and a 0-to-1 transition of the result starts a conversion. `conv_start` is high in the cycle after the third rising clock edge that follows the input change. Transitions on unselected inputs do nothing.
- R3: With bit 27 = 1, a falling trigger input starts a conversion and a rising one does not.
- R4: `conv_clk_en` is low while idle. Once a conversion starts, it pulses every DIV+1 cycles, with DIV taken from bits 15:8. The first pulse comes DIV cycles after the cycle in which `conv_start` is high (the same cycle when DIV = 0).
- R5: A `core_done` pulse sets DONE (result word bit 31) and `irq`. It places `core_chan` in bits 26:24 and `core_result` in bits 15:6. Bits 29:27, 23:16 and 5:0 read as zero.
- R6: A read access to the result word (address 1 with `bus_rd`) clears DONE and OVERRUN. If `core_done` arrives in the same cycle, DONE ends that cycle set.
- R7: A control write while idle clears DONE. A control write while a conversion runs sets DONE and restarts a conversion, with `conv_start` high in the next cycle.
- R8: Writing bit 16 = 1 starts burst mode. Each completion starts the next conversion at once, on the next set mask bit in ascending order, wrapping around after the highest one. A completion that arrives while DONE is still set in burst mode sets OVERRUN (bit 30).
- R9: Trigger transitions that arrive while a conversion is running are ignored.
- R10: The control word reads back bits 27:24, bit 16 and bits 15:0 as written, and all other bits as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; only address 0 is writable |
| bus_rd | input | 1 | Read access strobe; clears flags when address is 1 |
| bus_addr | input | 1 | 0 = control word, 1 = result word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| trig_in | input | 6 | Asynchronous hardware trigger sources |
| conv_start | output | 1 | One-cycle conversion start pulse to the core |
| conv_chan | output | 3 | Channel for the conversion being started |
| conv_clk_en | output | 1 | Divided conversion clock enable |
| core_done | input | 1 | Core completion pulse |
| core_result | input | 10 | Conversion result |
| core_chan | input | 3 | Channel of the finished conversion |
| irq | output | 1 | Interrupt request, high while DONE is set |

## Verification
The hardest case to reach is a result-word read landing in exactly the same cycle as a core completion. Reaching it means taking the converter core away from the automatic bench model and pulsing `core_done` by hand in the cycle of the read strobe. Overrun is reached by letting burst mode run for several conversions with no reads. Busy-time control writes and ignored trigger edges rely on a long divider setting, so that the conversion stays open while the stimulus is applied.

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [5:0]  trig_in,
  output logic        conv_start,
  output logic [2:0]  conv_chan,
  output logic        conv_clk_en,
  input  logic        core_done,
  input  logic [9:0]  core_result,
  input  logic [2:0]  core_chan,
  output logic        irq
);

  logic [7:0]       mask_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic             burst_q, pol_q, prev_q;
  logic [2:0]       code_q;
  logic             busy_q, done_q, ovr_q;
  logic [9:0]       res_q;
  logic [2:0]       chn_q;
  logic [5:0]       sync1_q, sync2_q;

  function automatic logic [2:0] pick_next(input logic [7:0] m, input logic [2:0] cur);
    logic [2:0] r;
    logic       hit;
    r = 3'd0;
    hit = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      logic [2:0] idx;
      idx = cur + 3'(k);
      if (!hit && m[idx]) begin
        r = idx;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  wire        ctrl_wr   = bus_wr && !bus_addr;
  wire        data_rd   = bus_rd && bus_addr;
  wire [2:0]  w_code    = bus_wdata[26:24];
  wire        w_burst   = bus_wdata[16];
  wire [7:0]  trig_ext  = {sync2_q, 2'b00};
  wire        lvl       = trig_ext[code_q] ^ pol_q;
  wire        w_lvl     = trig_ext[w_code] ^ bus_wdata[27];
  wire        wr_go     = ctrl_wr && (busy_q || w_burst || w_code == 3'b001);
  wire        burst_go  = core_done && busy_q && burst_q && !ctrl_wr;
  wire        hw_go     = !burst_q && code_q >= 3'd2 && lvl && !prev_q && !busy_q && !ctrl_wr;
  wire        restart   = wr_go || burst_go || hw_go;
  wire        unused_wbits = ^{bus_wdata[31:28], bus_wdata[23:17]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0; div_q <= '0; burst_q <= 1'b0; code_q <= '0; pol_q <= 1'b0;
      sync1_q <= '0; sync2_q <= '0; prev_q <= 1'b0;
      busy_q <= 1'b0; conv_start <= 1'b0; conv_chan <= '0;
    end else begin
      sync1_q    <= trig_in;
      sync2_q    <= sync1_q;
      prev_q     <= ctrl_wr ? w_lvl : lvl;
      conv_start <= 1'b0;
      if (ctrl_wr) begin
        mask_q  <= bus_wdata[7:0];
        div_q   <= bus_wdata[8 +: DIV_W];
        burst_q <= w_burst;
        code_q  <= w_code;
        pol_q   <= bus_wdata[27];
      end
      if (wr_go) begin
        conv_start <= 1'b1;
        busy_q     <= 1'b1;
        conv_chan  <= pick_next(bus_wdata[7:0], 3'd7);
      end else if (burst_go) begin
        conv_start <= 1'b1;
        conv_chan  <= pick_next(mask_q, conv_chan);
      end else if (hw_go) begin
        conv_start <= 1'b1;
        busy_q     <= 1'b1;
        conv_chan  <= pick_next(mask_q, 3'd7);
      end else if (core_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; ovr_q <= 1'b0; res_q <= '0; chn_q <= '0;
    end else if (core_done) begin
      done_q <= 1'b1;
      res_q  <= core_result;
      chn_q  <= core_chan;
      if (burst_q && done_q && !data_rd) ovr_q <= 1'b1;
      else if (data_rd)                  ovr_q <= 1'b0;
    end else if (ctrl_wr) begin
      done_q <= busy_q;
    end else if (data_rd) begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (restart || !busy_q) cnt_q <= '0;
    else if (cnt_q == div_q)     cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign conv_clk_en = busy_q && (cnt_q == div_q);
  assign irq = done_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr) begin
      bus_rdata = {done_q, ovr_q, 3'b000, chn_q, 8'h00, res_q, 6'b000000};
    end else begin
      bus_rdata[7:0]      = mask_q;
      bus_rdata[8+:DIV_W] = div_q;
      bus_rdata[16]       = burst_q;
      bus_rdata[26:24]    = code_q;
      bus_rdata[27]       = pol_q;
    end
  end

  AST_DONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) core_done |=> done_q); // R5
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (data_rd && !core_done) |=> (!done_q && !ovr_q)); // R6
  AST_READ_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n) (data_rd && core_done) |=> done_q); // R6
  AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_wr && busy_q) |=> (done_q && conv_start)); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && !ctrl_wr && !(core_done && burst_q)) |=> !conv_start); // R9
  AST_CLK_PHASE: assert property (@(posedge clk) disable iff (!rst_n) $rose(conv_start) |-> (conv_clk_en == (div_q == '0))); // R4
  AST_OVR_BURST: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr_q) |-> $past(burst_q)); // R8

endmodule

// File: tb/adc_seq_ctl_tb.sv
module adc_seq_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b1;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  trig_in = '0;
  logic        conv_start, conv_clk_en, irq;
  logic [2:0]  conv_chan;
  logic        core_done;
  logic [9:0]  core_result;
  logic [2:0]  core_chan;

  logic        auto_core = 1'b1;
  logic        man_done = 1'b0;
  logic [9:0]  man_res = '0;
  logic [2:0]  man_chan = '0;
  logic        m_done, m_pend;
  logic [9:0]  m_res;
  logic [2:0]  m_chan, m_lch;
  int          m_n;
  int          starts = 0;
  int          nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  adc_seq_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_clk_en(conv_clk_en),
    .core_done(core_done), .core_result(core_result), .core_chan(core_chan), .irq(irq)
  );

  assign core_done   = auto_core ? m_done : man_done;
  assign core_result = auto_core ? m_res  : man_res;
  assign core_chan   = auto_core ? m_chan : man_chan;

  function automatic logic [9:0] res_of(input logic [2:0] ch);
    return 10'h2A5 ^ {7'b0, ch};
  endfunction

  function automatic logic [31:0] dword(input logic d, input logic o, input logic [2:0] ch, input logic [9:0] r);
    return {d, o, 3'b000, ch, 8'h00, r, 6'b000000};
  endfunction

  always @(posedge clk) begin
    if (conv_start) starts <= starts + 1;
    if (!rst_n) begin
      m_done <= 1'b0; m_pend <= 1'b0; m_n <= 0; m_res <= '0; m_chan <= '0; m_lch <= '0;
    end else begin
      m_done <= 1'b0;
      if (conv_start) begin
        m_pend <= 1'b1; m_n <= 0; m_lch <= conv_chan;
      end else if (m_pend && conv_clk_en) begin
        if (m_n == 2) begin
          m_done <= 1'b1; m_pend <= 1'b0; m_res <= res_of(m_lch); m_chan <= m_lch;
        end else m_n <= m_n + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b1;
  endtask

  task automatic data_read(output logic [31:0] v);
    bus_addr = 1'b1;
    v = bus_rdata;
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R5 reset result word", bus_rdata, 32'h0);
    chk("R5 reset irq", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      chk("R4 idle conv_clk_en", {31'b0, conv_clk_en}, 32'h0);
      @(negedge clk);
    end
    v = '0;
    chk("R1 no start at reset", starts, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    ctrl_write(32'hF8FE_A5C3);
    bus_addr = 1'b0;
    #1 v = bus_rdata;
    bus_addr = 1'b1;
    chk("R10 control readback", v, 32'h0800_A5C3);
    chk("R10 no start from code 000", starts, 0);
  endtask

  task automatic t_sw_start();
    logic [31:0] v;
    ctrl_write(32'h0100_0028);
    chk("R1 conv_start pulse", {31'b0, conv_start}, 32'h1);
    chk("R1 lowest mask channel", {29'b0, conv_chan}, 32'd3);
    wait_irq();
    chk("R5 irq on done", {31'b0, irq}, 32'h1);
    chk("R5 result word", bus_rdata, dword(1'b1, 1'b0, 3'd3, res_of(3'd3)));
    data_read(v);
    chk("R6 read clears DONE", bus_rdata, dword(1'b0, 1'b0, 3'd3, res_of(3'd3)));
    chk("R6 irq cleared", {31'b0, irq}, 32'h0);
    ctrl_write(32'h0100_0000);
    chk("R1 zero mask gives channel 0", {29'b0, conv_chan}, 32'd0);
    wait_irq();
    data_read(v);
    chk("R5 channel 0 result", v, dword(1'b1, 1'b0, 3'd0, res_of(3'd0)));
  endtask

  task automatic t_divider();
    logic [31:0] v;
    ctrl_write(32'h0100_0301);
    for (int c = 0; c < 8; c++) begin
      chk($sformatf("R4 clk_en cycle %0d", c), {31'b0, conv_clk_en}, (c == 3 || c == 7) ? 32'h1 : 32'h0);
      @(negedge clk);
    end
    wait_irq();
    data_read(v);
    chk("R4 divided conversion completes", v, dword(1'b1, 1'b0, 3'd0, res_of(3'd0)));
    cycles(3);
    chk("R4 clk_en off when idle", {31'b0, conv_clk_en}, 32'h0);
  endtask

  task automatic t_hw_rise();
    int s0;
    logic [31:0] v;
    ctrl_write(32'h0300_0010);
    s0 = starts;
    trig_in[0] = 1'b1;
    cycles(6);
    chk("R2 unselected input ignored", starts, s0);
    trig_in[0] = 1'b0;
    cycles(2);
    trig_in[1] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 no start before third edge", {31'b0, conv_start}, 32'h0);
    @(negedge clk);
    chk("R2 start after third edge", {31'b0, conv_start}, 32'h1);
    chk("R2 channel", {29'b0, conv_chan}, 32'd4);
    wait_irq();
    data_read(v);
    chk("R2 triggered result", v, dword(1'b1, 1'b0, 3'd4, res_of(3'd4)));
    trig_in[1] = 1'b0;
    cycles(4);
  endtask

  task automatic t_hw_fall();
    int s0;
    logic [31:0] v;
    ctrl_write(32'h0F00_0080);
    s0 = starts;
    trig_in[5] = 1'b1;
    cycles(8);
    chk("R3 rising edge ignored with bit27", starts, s0);
    trig_in[5] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R3 no start before third edge", {31'b0, conv_start}, 32'h0);
    @(negedge clk);
    chk("R3 falling edge starts", {31'b0, conv_start}, 32'h1);
    chk("R3 channel", {29'b0, conv_chan}, 32'd7);
    wait_irq();
    data_read(v);
    chk("R3 result", v, dword(1'b1, 1'b0, 3'd7, res_of(3'd7)));
  endtask

  task automatic t_busy_ignore();
    int s0;
    logic [31:0] v;
    ctrl_write(32'h0200_0F04);
    trig_in[0] = 1'b1;
    cycles(4);
    s0 = starts;
    chk("R9 first edge started", s0 > 0 ? 32'h1 : 32'h0, 32'h1);
    for (int i = 0; i < 3; i++) begin
      trig_in[0] = 1'b0; cycles(3);
      trig_in[0] = 1'b1; cycles(3);
    end
    chk("R9 edges while busy ignored", starts, s0);
    chk("R9 still converting", {31'b0, irq}, 32'h0);
    wait_irq();
    data_read(v);
    chk("R9 single result", v, dword(1'b1, 1'b0, 3'd2, res_of(3'd2)));
    chk("R9 no extra start", starts, s0);
    trig_in[0] = 1'b0;
    cycles(4);
  endtask

  task automatic t_write_busy();
    logic [31:0] v;
    ctrl_write(32'h0100_0F02);
    cycles(5);
    chk("R7 busy, DONE low", {31'b0, irq}, 32'h0);
    ctrl_write(32'h0000_0000);
    chk("R7 busy write sets DONE", {31'b0, irq}, 32'h1);
    chk("R7 busy write restarts", {31'b0, conv_start}, 32'h1);
    cycles(20);
    chk("R7 restarted conversion result", bus_rdata, dword(1'b1, 1'b0, 3'd0, res_of(3'd0)));
    ctrl_write(32'h0000_0000);
    chk("R7 idle write clears DONE", {31'b0, irq}, 32'h0);
    chk("R7 idle write no start", {31'b0, conv_start}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    auto_core = 1'b0;
    ctrl_write(32'h0100_0040);
    cycles(2);
    man_done = 1'b1; man_res = 10'h155; man_chan = 3'd6;
    bus_addr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    man_done = 1'b0; bus_rd = 1'b0;
    chk("R6 completion wins over read", {31'b0, irq}, 32'h1);
    chk("R6 collided result word", bus_rdata, dword(1'b1, 1'b0, 3'd6, 10'h155));
    data_read(v);
    chk("R6 later read clears", {31'b0, irq}, 32'h0);
    cycles(10);
    auto_core = 1'b1;
  endtask

  task automatic t_burst();
    logic [31:0] v;
    logic [2:0] exp_ch[4] = '{3'd1, 3'd4, 3'd7, 3'd1};
    int s0;
    ctrl_write(32'h0001_0092);
    chk("R8 burst starts", {31'b0, conv_start}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      wait_irq();
      data_read(v);
      chk($sformatf("R8 burst step %0d", i), v, dword(1'b1, 1'b0, exp_ch[i], res_of(exp_ch[i])));
    end
    cycles(40);
    chk("R8 overrun set", {30'b0, bus_rdata[31:30]}, 32'h3);
    ctrl_write(32'h0000_0000);
    cycles(20);
    data_read(v);
    chk("R6 read clears DONE and OVERRUN", {30'b0, bus_rdata[31:30]}, 32'h0);
    s0 = starts;
    cycles(20);
    chk("R8 burst stopped", starts, s0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    cycles(5);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_sw_start();
    t_divider();
    t_hw_rise();
    t_hw_fall();
    t_busy_ignore();
    t_write_busy();
    t_collide();
    t_burst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule